// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block takes a stereo PCM stream carried on three wires (a bit clock, a word clock and a serial data line) and turns it into a pair of parallel samples, left and right. The sender's bit clock and word clock are inputs only; the receiver does not generate them. All three wires pass through a synchroniser into the system clock domain. Rising edges of the bit clock are detected there, and every detected edge samples one data bit together with the level of the word clock.

A 3-bit format code selects the framing. Four codes select right-justified words of 24, 20, 18 or 16 bits, one selects I2S and one selects left-justified. The framing decides which word-clock level marks the left channel and where the most significant bit sits inside each channel slot. Each channel word is delivered as a two's complement value aligned to the top of a 24-bit field. Once a left word and then a right word of the same frame have both been captured, the two words appear together on the outputs with a one-cycle strobe.

Top module: `audio_serial_rx`

## Requirements
- R1: After reset, left_o and right_o are zero and frame_valid_o and fmt_err_o are low. The active format is left-justified (code 101) until the first word-clock transition, even when fmt_i holds another code during and after reset.
- R2: A data bit is taken on each rising edge of the bit clock, most significant bit first. Every output word is SAMPLE_W bits wide, with the first received bit in the top position.
- R3: Left-justified (code 101): word clock high marks the left channel, and the MSB is the bit taken on the first rising bit-clock edge after the word-clock transition. At most the first 24 bits of a slot are kept. Any positions not received, as with 16-bit slots, read as zero.
- R4: I2S (code 100): word clock low marks the left channel, and the MSB arrives one bit-clock period after the transition. The bit taken on the first rising edge after a transition is the last bit of the previous channel, so a 24-bit word fits a 24-bit slot.
- R5: Right-justified, with codes 000, 001, 010 and 011 giving 24, 20, 18 and 16 bits: word clock high marks the left channel. The word is the last N bits taken before the word-clock transition, and earlier bits of the slot have no effect on the output.
- R6: frame_valid_o pulses for exactly one cycle when a right word completes a frame whose left word was already captured. left_o and right_o change only in a cycle where frame_valid_o is high.
- R7: fmt_i is taken at each word-clock transition. When the code taken differs from the active one, the channel just ending and any unpaired left word are discarded, and the next complete left/right pair is reported in the new format.
- R8: While the active code is reserved (110 or 111), fmt_err_o is high, no strobe is produced and left_o and right_o hold their last values. Normal operation resumes once a valid code is taken at a word-clock transition.
- R9: Slots of 16, 24 and 32 bits per channel (bit clock at 32, 48 or 64 times the frame rate) are accepted. I2S is used with 24- and 32-bit slots only.
- R10: The bit clock, word clock and data inputs may be asynchronous to clk. Correct capture requires each bit-clock phase to last at least two clk periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_i | input | 3 | Framing code, taken at word-clock transitions |
| bclk_i | input | 1 | Serial bit clock |
| wclk_i | input | 1 | Word clock (channel select) |
| sdata_i | input | 1 | Serial data |
| left_o | output | SAMPLE_W | Last complete left word, top-aligned |
| right_o | output | SAMPLE_W | Last complete right word, top-aligned |
| frame_valid_o | output | 1 | One-cycle strobe when a new left/right pair is presented |
| fmt_err_o | output | 1 | High while the active code is reserved |

## Verification
The assertions assume that two finished channel words are always separated by several system clocks. That holds only when bit-clock phases span at least two clk periods, because a word can only end on a detected bit-clock edge. The bench therefore holds each bit-clock phase for two or three clk periods, chosen at random per burst. It changes the word clock and data only while the bit clock is low, so both are stable for at least two clk periods before the synchronised rising edge. It changes fmt_i only between bursts, while the bit clock is idle.

// File: rtl/aurx_pkg.sv
package aurx_pkg;

   typedef enum logic [2:0] {
      FMT_RJ24 = 3'b000,
      FMT_RJ20 = 3'b001,
      FMT_RJ18 = 3'b010,
      FMT_RJ16 = 3'b011,
      FMT_I2S  = 3'b100,
      FMT_LJ   = 3'b101,
      FMT_RSV6 = 3'b110,
      FMT_RSV7 = 3'b111
   } fmt_e;

   // codes 110 and 111 carry no framing
   function automatic logic fmt_reserved(input logic [2:0] f);
      return f[2] & f[1];
   endfunction

   // right-justified formats are the codes with the top bit clear
   function automatic logic fmt_is_rj(input logic [2:0] f);
      return ~f[2];
   endfunction

   function automatic int unsigned rj_len(input logic [2:0] f);
      case (f[1:0])
         2'b00:   return 24;
         2'b01:   return 20;
         2'b10:   return 18;
         default: return 16;
      endcase
   endfunction

endpackage

// File: rtl/aurx_sync.sv
module aurx_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("aurx_sync: STAGES must be 2 or more");
   end
   if (W < 1) begin : g_bad_w
      $error("aurx_sync: W must be positive");
   end

   logic [STAGES-1:0][W-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-2:0], d_i};
   end

   assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/aurx_slot.sv
module aurx_slot
   import aurx_pkg::*;
#(
   parameter int SAMPLE_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          fmt_i,
   input  logic                bclk_s,
   input  logic                wclk_s,
   input  logic                dat_s,
   output logic                word_stb_o,
   output logic [SAMPLE_W-1:0] word_val_o,
   output logic                word_left_o,
   output logic                resync_o,
   output logic                fmt_err_o
);

   localparam int CNT_W = $clog2(SAMPLE_W + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SAMPLE_W);
   localparam logic [CNT_W-1:0] TOP_POS = CNT_W'(SAMPLE_W - 1);

   logic [2:0]          fmt_q;
   logic                bclk_q, wl_last, primed, started;
   logic [CNT_W-1:0]    cnt;
   logic [SAMPLE_W-1:0] cap, sr, bit_w, cap_plus, rj_val, fin_val;
   logic                rise, wc_flip, fmt_chg, old_i2s, new_i2s, fin_ok;

   always_comb begin
      rise     = bclk_s & ~bclk_q;
      wc_flip  = rise & primed & (wclk_s != wl_last);
      fmt_chg  = (fmt_i != fmt_q);
      old_i2s  = (fmt_q == FMT_I2S);
      new_i2s  = (fmt_i == FMT_I2S);
      bit_w    = {{(SAMPLE_W-1){1'b0}}, dat_s};
      cap_plus = (cnt < CNT_MAX) ? (cap | (bit_w << (TOP_POS - cnt))) : cap;
      // last N bits sit at the bottom of sr; shifting them up drops the rest
      rj_val   = sr << (SAMPLE_W - rj_len(fmt_q));
      if (fmt_is_rj(fmt_q)) fin_val = rj_val;
      else if (old_i2s)     fin_val = cap_plus;
      else                  fin_val = cap;
      fin_ok   = wc_flip & started & ~fmt_chg & ~fmt_reserved(fmt_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fmt_q       <= FMT_LJ;
         bclk_q      <= 1'b0;
         wl_last     <= 1'b0;
         primed      <= 1'b0;
         started     <= 1'b0;
         cnt         <= '0;
         cap         <= '0;
         sr          <= '0;
         word_stb_o  <= 1'b0;
         word_val_o  <= '0;
         word_left_o <= 1'b0;
         resync_o    <= 1'b0;
      end else begin
         bclk_q     <= bclk_s;
         word_stb_o <= fin_ok;
         resync_o   <= wc_flip & fmt_chg;
         if (fin_ok) begin
            word_val_o  <= fin_val;
            word_left_o <= old_i2s ? ~wl_last : wl_last;
         end
         if (rise) begin
            primed  <= 1'b1;
            wl_last <= wclk_s;
            sr      <= {sr[SAMPLE_W-2:0], dat_s};
            if (wc_flip) begin
               fmt_q   <= fmt_i;
               started <= 1'b1;
               if (new_i2s) begin
                  cap <= '0;
                  cnt <= '0;
               end else begin
                  cap <= bit_w << (SAMPLE_W - 1);
                  cnt <= CNT_W'(1);
               end
            end else begin
               cap <= cap_plus;
               if (cnt < CNT_MAX) cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end

   assign fmt_err_o = fmt_reserved(fmt_q);

endmodule

// File: rtl/aurx_frame.sv
module aurx_frame #(
   parameter int SAMPLE_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                word_stb_i,
   input  logic [SAMPLE_W-1:0] word_val_i,
   input  logic                word_left_i,
   input  logic                drop_i,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic                frame_valid_o
);

   logic [SAMPLE_W-1:0] hold_l;
   logic                have_l;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_l        <= '0;
         have_l        <= 1'b0;
         left_o        <= '0;
         right_o       <= '0;
         frame_valid_o <= 1'b0;
      end else begin
         frame_valid_o <= 1'b0;
         if (drop_i) begin
            have_l <= 1'b0;
         end else if (word_stb_i) begin
            if (word_left_i) begin
               hold_l <= word_val_i;
               have_l <= 1'b1;
            end else if (have_l) begin
               left_o        <= hold_l;
               right_o       <= word_val_i;
               frame_valid_o <= 1'b1;
               have_l        <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx #(
   parameter int SAMPLE_W    = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          fmt_i,
   input  logic                bclk_i,
   input  logic                wclk_i,
   input  logic                sdata_i,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic                frame_valid_o,
   output logic                fmt_err_o
);

   if (SAMPLE_W < 24) begin : g_bad_sample_w
      $error("audio_serial_rx: SAMPLE_W must hold a 24-bit word");
   end

   logic [2:0]          pins_s;
   logic                word_stb, word_left, resync;
   logic [SAMPLE_W-1:0] word_val;

   aurx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({bclk_i, wclk_i, sdata_i}),
      .q_o   (pins_s)
   );

   aurx_slot #(.SAMPLE_W(SAMPLE_W)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .fmt_i       (fmt_i),
      .bclk_s      (pins_s[2]),
      .wclk_s      (pins_s[1]),
      .dat_s       (pins_s[0]),
      .word_stb_o  (word_stb),
      .word_val_o  (word_val),
      .word_left_o (word_left),
      .resync_o    (resync),
      .fmt_err_o   (fmt_err_o)
   );

   aurx_frame #(.SAMPLE_W(SAMPLE_W)) u_frame (
      .clk           (clk),
      .rst_n         (rst_n),
      .word_stb_i    (word_stb),
      .word_val_i    (word_val),
      .word_left_i   (word_left),
      .drop_i        (resync | fmt_err_o),
      .left_o        (left_o),
      .right_o       (right_o),
      .frame_valid_o (frame_valid_o)
   );

endmodule

// File: rtl/aurx_chk.sv
module aurx_chk #(
   parameter int SAMPLE_W = 24
) (
   input logic                clk,
   input logic                rst_n,
   input logic [1:0]          fmt_hi,
   input logic [SAMPLE_W-1:0] left_o,
   input logic [SAMPLE_W-1:0] right_o,
   input logic                frame_valid_o,
   input logic                fmt_err_o
);

   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!frame_valid_o && !fmt_err_o));

   p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid_o |=> !frame_valid_o);

   p_left_moves_with_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(left_o) |-> frame_valid_o);

   p_right_moves_with_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(right_o) |-> frame_valid_o);

   p_err_silences_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_err_o |-> !frame_valid_o);

   p_err_from_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fmt_err_o) |-> ($past(fmt_hi) == 2'b11));

endmodule

bind audio_serial_rx aurx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .fmt_hi        (fmt_i[2:1]),
   .left_o        (left_o),
   .right_o       (right_o),
   .frame_valid_o (frame_valid_o),
   .fmt_err_o     (fmt_err_o)
);

// File: tb/tb_audio_serial_rx.sv
module tb_audio_serial_rx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  fmt_i = 3'b101;
   logic        bclk_i = 1'b0, wclk_i = 1'b0, sdata_i = 1'b0;
   logic [23:0] left_o, right_o;
   logic        frame_valid_o, fmt_err_o;

   int errors = 0, checks = 0;
   int half = 2;
   logic carry = 1'b0;
   logic [23:0] exp_l[$];
   logic [23:0] exp_r[$];
   string cur_tag = "R1";
   bit done = 0;

   always #4 clk = ~clk;

   audio_serial_rx dut (
      .clk(clk), .rst_n(rst_n), .fmt_i(fmt_i), .bclk_i(bclk_i),
      .wclk_i(wclk_i), .sdata_i(sdata_i), .left_o(left_o),
      .right_o(right_o), .frame_valid_o(frame_valid_o), .fmt_err_o(fmt_err_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int rjn(input logic [2:0] f);
      case (f[1:0])
         2'b00: return 24;
         2'b01: return 20;
         2'b10: return 18;
         default: return 16;
      endcase
   endfunction

   function automatic logic [23:0] top_bits(input logic [23:0] s, input int n);
      logic [31:0] m;
      m = 32'hFFFF_FFFF << (24 - n);
      return s & m[23:0];
   endfunction

   function automatic logic [23:0] exp_word(input logic [2:0] f, input int slot,
                                            input int wlen, input logic [23:0] s);
      if (!f[2]) return top_bits(s, rjn(f));
      return top_bits(s, (wlen < slot) ? wlen : slot);
   endfunction

   function automatic logic slot_bit(input logic [2:0] f, input int slot, input int wlen,
                                     input logic [23:0] s, input int k);
      int off;
      if (!f[2]) begin
         off = slot - rjn(f);
         if (k < off) return 1'($urandom % 2);   // leading slot bits are junk
         return s[23 - (k - off)];
      end
      if (k < wlen && k < 24) return s[23 - k];
      return 1'b0;
   endfunction

   task automatic tx_bit(input logic d, input logic w);
      @(negedge clk);
      bclk_i = 1'b0; sdata_i = d; wclk_i = w;
      repeat (half - 1) @(negedge clk);
      @(negedge clk);
      bclk_i = 1'b1;
      repeat (half - 1) @(negedge clk);
   endtask

   task automatic emit(input logic i2s, input logic d, input logic w);
      if (i2s) begin
         tx_bit(carry, w);
         carry = d;
      end else begin
         tx_bit(d, w);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; bclk_i = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // code: fmt_i value; shape: framing actually sent
   task automatic run_burst(input logic [2:0] code, input logic [2:0] shape,
                            input int slot, input int wlen, input int nfr,
                            input bit rst_first, input bit expect_out, input string tag);
      logic i2s, lvl_l;
      logic [23:0] sl, sr;
      cur_tag = tag;
      half = 2 + int'($urandom % 2);
      carry = 1'b0;
      fmt_i = code;
      if (rst_first) do_reset();
      i2s = (shape == 3'b100);
      lvl_l = i2s ? 1'b0 : 1'b1;
      for (int k = 0; k < 4; k++) emit(i2s, 1'b0, ~lvl_l);
      for (int fr = 0; fr < nfr; fr++) begin
         sl = 24'($urandom);
         sr = 24'($urandom);
         if (expect_out) begin
            exp_l.push_back(exp_word(shape, slot, wlen, sl));
            exp_r.push_back(exp_word(shape, slot, wlen, sr));
         end
         for (int k = 0; k < slot; k++) emit(i2s, slot_bit(shape, slot, wlen, sl, k), lvl_l);
         for (int k = 0; k < slot; k++) emit(i2s, slot_bit(shape, slot, wlen, sr, k), ~lvl_l);
      end
      for (int k = 0; k < 4; k++) emit(i2s, 1'b0, lvl_l);
      repeat (12) @(negedge clk);
      chk({tag, " R6 frames outstanding"}, exp_l.size(), 0);
   endtask

   // frame monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n && frame_valid_o) begin
         if (exp_l.size() == 0) begin
            chk({cur_tag, " R6 unexpected strobe"}, 1, 0);
         end else begin
            chk({cur_tag, " left word"}, left_o, exp_l.pop_front());
            chk({cur_tag, " right word"}, right_o, exp_r.pop_front());
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [23:0] held_l, held_r;
      void'($urandom(32'd20240611));

      // R1: reset state, default format in force despite a reserved code on fmt_i
      fmt_i = 3'b111;
      do_reset();
      chk("R1 left after reset", left_o, 0);
      chk("R1 right after reset", right_o, 0);
      chk("R1 strobe after reset", frame_valid_o, 0);
      chk("R1 err after reset", fmt_err_o, 0);
      for (int k = 0; k < 3; k++) tx_bit(1'b1, 1'b0);
      repeat (6) @(negedge clk);
      chk("R1 err before transition", fmt_err_o, 0);
      tx_bit(1'b0, 1'b1);
      repeat (6) @(negedge clk);
      chk("R8 err after reserved code taken", fmt_err_o, 1);

      // R3 R2 R9 R10: left-justified, 64/48/32 bit clocks
      run_burst(3'b101, 3'b101, 32, 24, 4, 1, 1, "R3 R2 LJ 64fs");
      run_burst(3'b101, 3'b101, 24, 20, 4, 1, 1, "R3 R9 LJ 48fs 20b");
      run_burst(3'b101, 3'b101, 16, 24, 4, 1, 1, "R3 R9 LJ 32fs zero fill");
      // R4: I2S
      run_burst(3'b100, 3'b100, 32, 24, 4, 1, 1, "R4 I2S 64fs");
      run_burst(3'b100, 3'b100, 24, 24, 4, 1, 1, "R4 I2S 48fs full slot");
      run_burst(3'b100, 3'b100, 32, 16, 4, 1, 1, "R4 I2S 64fs 16b");
      // R5: right-justified widths
      run_burst(3'b000, 3'b000, 32, 24, 4, 1, 1, "R5 RJ24 64fs");
      run_burst(3'b001, 3'b001, 24, 20, 4, 1, 1, "R5 RJ20 48fs");
      run_burst(3'b010, 3'b010, 32, 18, 4, 1, 1, "R5 RJ18 64fs");
      run_burst(3'b011, 3'b011, 16, 16, 4, 1, 1, "R5 RJ16 32fs R10");
      run_burst(3'b011, 3'b011, 32, 16, 4, 1, 1, "R5 RJ16 64fs junk lead");

      // R7: change format mid-stream without reset
      run_burst(3'b101, 3'b101, 32, 24, 3, 1, 1, "R7 LJ before change");
      run_burst(3'b100, 3'b100, 32, 24, 3, 0, 1, "R7 I2S after change");
      chk("R7 err stays low", fmt_err_o, 0);

      // R8: reserved code holds outputs, then recovers
      held_l = left_o;
      held_r = right_o;
      run_burst(3'b110, 3'b101, 32, 24, 3, 0, 0, "R8 reserved");
      chk("R8 err high", fmt_err_o, 1);
      chk("R8 left held", left_o, held_l);
      chk("R8 right held", right_o, held_r);
      run_burst(3'b101, 3'b101, 32, 24, 3, 0, 1, "R8 recovery");
      chk("R8 err cleared", fmt_err_o, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule